// File: doc/BRIEF.md
# PCI Initiator Request Queue

This block sits between two request sources and a PCI initiator engine. It holds up to four pending transaction descriptors, each made of a target address, a word count, byte enables and a 4-bit PCI command. Descriptors leave the queue in arrival order through a valid/ready handshake.

The first source is a bus-slave port. A bus master uses it for interrupt acknowledge, special cycles, I/O and configuration accesses, and single-word memory reads and writes. This port has no count input, so its entries always carry a count of one. The second source is a DMA channel port, which issues burst memory requests with a count it supplies.

The block answers every request in the same cycle it arrives, with exactly one of three responses:
- **ack**: the request is stored.
- **retry**: the queue is full, so the requesting master must try again.
- **err**: the command code is not allowed on that port.

Top module: `pci_req_queue`

## Requirements
- R1: After reset the queue is empty: out_valid is low and no port response is asserted while no request is presented.
- R2: The bus-slave port accepts only command codes 0x0, 0x1, 0x2, 0x3, 0x6, 0x7, 0xA and 0xB. Any other code raises bs_err in the same cycle and is never stored.
- R3: The DMA port accepts only command codes 0x6, 0x7, 0xC and 0xE. Any other code raises dma_err in the same cycle and is never stored.
- R4: The queue holds at most four entries. A legal request that arrives while four entries are held raises retry on its port and leaves the queue contents unchanged.
- R5: The accept decision uses only the occupancy at the start of the cycle. A legal request on a full queue is retried even when the initiator removes an entry in that same cycle.
- R6: A port that presents a request sees exactly one of ack, retry or err, combinationally in that cycle. It sees none of them when it presents no request, except as stated in R7.
- R7: When both ports present legal requests in the same cycle, only the bus-slave request is decided. The DMA port gets no response that cycle and, while holding its request, is decided on the following cycle.
- R8: Entries leave the queue in arrival order. The head entry is removed on a clock edge where out_valid and out_ready are both high. While out_valid is high and out_ready is low, the head stays valid and unchanged.
- R9: An entry from the bus-slave port is stored with count 1. An entry from the DMA port keeps its supplied count. Address, byte enables and command are stored as presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bs_req | input | 1 | Bus-slave request present |
| bs_addr | input | ADDR_W | Bus-slave target address |
| bs_be | input | BE_W | Bus-slave byte enables |
| bs_cmd | input | 4 | Bus-slave PCI command |
| bs_ack | output | 1 | Bus-slave request stored |
| bs_retry | output | 1 | Bus-slave request refused, queue full |
| bs_err | output | 1 | Bus-slave command not allowed |
| dma_req | input | 1 | DMA request present |
| dma_addr | input | ADDR_W | DMA target address |
| dma_cnt | input | CNT_W | DMA word count |
| dma_be | input | BE_W | DMA byte enables |
| dma_cmd | input | 4 | DMA PCI command |
| dma_ack | output | 1 | DMA request stored |
| dma_retry | output | 1 | DMA request refused, queue full |
| dma_err | output | 1 | DMA command not allowed |
| out_valid | output | 1 | Head entry available |
| out_ready | input | 1 | Initiator takes the head entry |
| out_addr | output | ADDR_W | Head entry address |
| out_cnt | output | CNT_W | Head entry word count |
| out_be | output | BE_W | Head entry byte enables |
| out_cmd | output | 4 | Head entry PCI command |

## Verification
The assertions check the following on every cycle:
- each port's responses are mutually exclusive;
- the bus-slave port wins over the DMA port;
- a legal request on a full queue is retried;
- occupancy never passes four;
- the head entry holds steady while the initiator stalls;
- a push without a pop raises occupancy by one;
- sample illegal codes raise an error.

Only the bench scenarios can show the rest:
- the full legality table for both ports;
- arrival order across mixed sources;
- the forced count of one;
- the retry that still happens on a full queue when a dequeue occurs in the same cycle;
- the proof that refused requests leave no trace in the queue.

// File: rtl/pci_req_queue.sv
module pci_req_queue #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int BE_W   = 4,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bs_req,
  input  logic [ADDR_W-1:0] bs_addr,
  input  logic [BE_W-1:0]   bs_be,
  input  logic [3:0]        bs_cmd,
  output logic              bs_ack,
  output logic              bs_retry,
  output logic              bs_err,
  input  logic              dma_req,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [CNT_W-1:0]  dma_cnt,
  input  logic [BE_W-1:0]   dma_be,
  input  logic [3:0]        dma_cmd,
  output logic              dma_ack,
  output logic              dma_retry,
  output logic              dma_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CNT_W-1:0]  out_cnt,
  output logic [BE_W-1:0]   out_be,
  output logic [3:0]        out_cmd
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int EW    = ADDR_W + CNT_W + BE_W + 4;
  localparam logic [15:0] BS_CMDS  = 16'h0CCF;
  localparam logic [15:0] DMA_CMDS = 16'h50C0;

  logic [EW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ;

  wire full      = (occ == OCC_W'(DEPTH));
  wire bs_legal  = BS_CMDS[bs_cmd];
  wire dma_legal = DMA_CMDS[dma_cmd];
  wire bs_take   = bs_req && bs_legal;
  wire dma_take  = dma_req && dma_legal && !bs_take;

  assign bs_ack    = bs_take && !full;
  assign bs_retry  = bs_take && full;
  assign bs_err    = bs_req && !bs_legal;
  assign dma_ack   = dma_take && !full;
  assign dma_retry = dma_take && full;
  assign dma_err   = dma_req && !dma_legal;

  wire push = bs_ack || dma_ack;
  wire pop  = out_valid && out_ready;

  wire [EW-1:0] new_ent = bs_ack ? {bs_addr, CNT_W'(1), bs_be, bs_cmd}
                                 : {dma_addr, dma_cnt, dma_be, dma_cmd};

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= new_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign out_valid = (occ != '0);
  assign {out_addr, out_cnt, out_be, out_cmd} = mem[rd_ptr];
endmodule

module pci_req_queue_chk #(
  parameter int DEPTH = 4,
  parameter int OCC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bs_req,
  input logic [3:0]       bs_cmd,
  input logic             bs_ack,
  input logic             bs_retry,
  input logic             bs_err,
  input logic             dma_req,
  input logic [3:0]       dma_cmd,
  input logic             dma_ack,
  input logic             dma_retry,
  input logic             dma_err,
  input logic             out_valid,
  input logic             out_ready,
  input logic [3:0]       out_cmd,
  input logic [OCC_W-1:0] occ
);
  // R6
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bs_ack, bs_retry, bs_err}) && $onehot0({dma_ack, dma_retry, dma_err}));
  // R7
  slave_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bs_ack |-> !dma_ack && !dma_retry);
  // R4
  full_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(DEPTH)) && bs_req && !bs_err |-> bs_retry && !bs_ack);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));
  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cmd));
  // R8
  occ_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_ack || dma_ack) && !(out_valid && out_ready) |=> occ == $past(occ) + 1'b1);
  // R2
  bs_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bs_req && (bs_cmd == 4'hD || bs_cmd == 4'hF || bs_cmd == 4'hC) |-> bs_err);
  // R3
  dma_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && (dma_cmd == 4'h2 || dma_cmd == 4'hB || dma_cmd == 4'hF) |-> dma_err);
endmodule

bind pci_req_queue pci_req_queue_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bs_req(bs_req), .bs_cmd(bs_cmd), .bs_ack(bs_ack), .bs_retry(bs_retry), .bs_err(bs_err),
  .dma_req(dma_req), .dma_cmd(dma_cmd), .dma_ack(dma_ack), .dma_retry(dma_retry),
  .dma_err(dma_err), .out_valid(out_valid), .out_ready(out_ready), .out_cmd(out_cmd),
  .occ(occ)
);

// File: tb/tb_pci_req_queue.sv
module tb_pci_req_queue;
  logic clk = 0, rst_n = 0;
  logic bs_req = 0, dma_req = 0, out_ready = 0;
  logic [31:0] bs_addr = 0, dma_addr = 0;
  logic [7:0] dma_cnt = 0;
  logic [3:0] bs_be = 0, dma_be = 0, bs_cmd = 0, dma_cmd = 0;
  logic bs_ack, bs_retry, bs_err, dma_ack, dma_retry, dma_err, out_valid;
  logic [31:0] out_addr;
  logic [7:0] out_cnt;
  logic [3:0] out_be, out_cmd;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pci_req_queue dut (.*);

  // {slave allowed, dma allowed} per command code
  localparam logic [1:0] OK_TBL [16] = '{
    2'b10, 2'b10, 2'b10, 2'b10, 2'b00, 2'b00, 2'b11, 2'b11,
    2'b00, 2'b00, 2'b10, 2'b10, 2'b01, 2'b00, 2'b01, 2'b00};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pop_one();
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 out_valid", out_valid, 0);
    check("R1 responses", {bs_ack, bs_retry, bs_err, dma_ack, dma_retry, dma_err}, 0);

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      bs_req = 1; bs_cmd = 4'(i); bs_addr = 32'h1000 + i; bs_be = 4'h5;
      #1;
      check($sformatf("R2 ack code %0h", i), bs_ack, OK_TBL[i][1]);
      check($sformatf("R2 err code %0h", i), bs_err, !OK_TBL[i][1]);
      @(negedge clk);
      bs_req = 0;
      #1;
      check($sformatf("R2 stored code %0h", i), out_valid, OK_TBL[i][1]);
      if (OK_TBL[i][1]) begin
        check("R9 slave fields", {out_addr, out_cnt, out_be, out_cmd},
              {32'h1000 + i, 8'd1, 4'h5, 4'(i)});
        pop_one();
      end
      @(negedge clk);
      dma_req = 1; dma_cmd = 4'(i); dma_addr = 32'h2000 + i; dma_cnt = 8'(16 + i); dma_be = 4'hA;
      #1;
      check($sformatf("R3 ack code %0h", i), dma_ack, OK_TBL[i][0]);
      check($sformatf("R3 err code %0h", i), dma_err, !OK_TBL[i][0]);
      check("R6 no slave response", {bs_ack, bs_retry, bs_err}, 0);
      @(negedge clk);
      dma_req = 0;
      #1;
      check($sformatf("R3 stored code %0h", i), out_valid, OK_TBL[i][0]);
      if (OK_TBL[i][0]) begin
        check("R9 dma fields", {out_addr, out_cnt, out_be, out_cmd},
              {32'h2000 + i, 8'(16 + i), 4'hA, 4'(i)});
        pop_one();
      end
    end

    // fill, then retry when full
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      dma_req = 1; dma_cmd = 4'h7; dma_addr = 32'd100 + k; dma_cnt = 8'(k + 2);
      #1;
      check("R4 fill ack", dma_ack, 1);
    end
    @(negedge clk);
    dma_addr = 32'd999;
    #1;
    check("R4 dma retry when full", {dma_ack, dma_retry}, 2'b01);
    @(negedge clk);
    dma_req = 0;
    out_ready = 1; bs_req = 1; bs_cmd = 4'h2; bs_addr = 32'd777;
    #1;
    check("R5 retry with same-cycle pop", {bs_ack, bs_retry}, 2'b01);
    @(negedge clk);
    out_ready = 0; bs_req = 0;
    for (int k = 1; k < 4; k++) begin
      #1;
      check("R8 order", {out_valid, out_addr}, {1'b1, 32'd100 + k});
      check("R9 dma count", out_cnt, 8'(k + 2));
      pop_one();
    end
    #1;
    check("R4 retried requests not stored", out_valid, 0);

    // priority: both legal in same cycle
    @(negedge clk);
    bs_req = 1; bs_cmd = 4'hA; bs_addr = 32'd55;
    dma_req = 1; dma_cmd = 4'hC; dma_addr = 32'd66; dma_cnt = 8'd9;
    #1;
    check("R7 slave wins", bs_ack, 1);
    check("R7 dma silent", {dma_ack, dma_retry, dma_err}, 0);
    @(negedge clk);
    bs_req = 0;
    #1;
    check("R7 dma next cycle", dma_ack, 1);
    @(negedge clk);
    dma_req = 0;
    out_ready = 0;
    #1;
    check("R8 head first", out_addr, 32'd55);
    @(negedge clk);
    #1;
    check("R8 head held while not ready", {out_valid, out_addr}, {1'b1, 32'd55});
    pop_one();
    #1;
    check("R8 second entry", {out_addr, out_cnt}, {32'd66, 8'd9});
    pop_one();

    // illegal slave code does not block dma
    @(negedge clk);
    bs_req = 1; bs_cmd = 4'hF; dma_req = 1; dma_cmd = 4'hE; dma_addr = 32'd88;
    #1;
    check("R2 err", bs_err, 1);
    check("R7 dma decided when slave illegal", dma_ack, 1);
    @(negedge clk);
    bs_req = 0; dma_req = 0;
    #1;
    check("R2 only dma stored", {out_valid, out_addr}, {1'b1, 32'd88});
    pop_one();
    #1;
    check("R8 empty at end", out_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule